// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-pin bidirectional general-purpose I/O port. Each pin has its own direction bit and output latch bit. A single active-low control bit turns on weak pull-ups for every pin that is configured as an input. Pin inputs pass through a two-flop synchronizer, and the bus reads that synchronized copy.

The upper pins (7 down to 4) feed a change detector. Each of these pins that is configured as an input is compared with a snapshot of its value. The snapshot is reloaded on every read or write of the data register. A difference on any of these pins sets a sticky flag, and the flag stays set on every cycle that the difference remains. Software services the flag in two steps: it first accesses the data register, which ends the mismatch, and then writes a clear to the control register. An enable bit gates the flag onto an interrupt request output.

Top module: `gpio_chg_port`

## Requirements
- R1: `pin_oe[i]` is the inverse of direction bit i (1 = input, 0 = output), and `pin_out` always shows the output latch. Writing address 0 loads the latch, and writing address 1 loads the direction register.
- R2: `pull_en[i]` is 1 exactly when pull-up disable (control bit 0) is 0 and direction bit i is 1. A pull-up is never on for a pin that drives.
- R3: After reset: direction reads 8'hFF, the latch is 0, control reads 3'b001 (pull-ups off, interrupt disabled, flag clear), the snapshot is 0 and `irq` is 0.
- R4: A read (`rd_en`) puts the register on `rdata` at the next clock edge. Address 0 returns the synchronized pin values, which lag `pin_in` by two clocks. Address 1 returns direction. Address 2 returns {5'b0, flag (bit 2), irq enable (bit 1), pull-up disable (bit 0)}. Address 3 returns 0.
- R5: The flag is set only by a pin among 7..4 that is configured as an input and whose synchronized value differs from the snapshot. Changes on pins 3..0, or on pins configured as outputs, never set it.
- R6: Any read or write of address 0 loads the snapshot with the synchronized value of pins 7..4 that was present in that cycle. A port read returns that same value.
- R7: A write to address 2 with bit 2 = 0 clears the flag, and a write with bit 2 = 1 leaves it unchanged. While a mismatch is present, the flag is set on every cycle, and this takes priority over a clear in the same cycle.
- R8: `irq` equals flag AND irq enable (control bit 1). The flag still sets while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 data, 1 direction, 2 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Output latch driven to pads |
| pin_oe | output | 8 | Per-pin output enable |
| pull_en | output | 8 | Per-pin weak pull-up enable |
| irq | output | 1 | Change interrupt request |

## Verification
Directed cases toggle a low pin, an upper input pin and an upper pin configured as an output. This separates the pins that take part in the comparison from those that do not. A clear attempted while a mismatch persists, compared with a clear issued after a port read, shows the set-over-clear priority and the role of the snapshot. Random bus traffic mixed with random pin activity is then checked cycle by cycle against a bench model. This exercises simultaneous accesses, clears and pin changes that directed cases would miss.

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int W      = 8,
  parameter int CHG_LO = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pull_en,
  output logic         irq
);
  localparam int CW = W - CHG_LO;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  logic [W-1:0]  meta_q, sync_q, lat_q, dir_q;
  logic [CW-1:0] snap_q;
  logic          pull_dis_q, irq_en_q, flag_q;
  logic          port_acc, clr_req, mismatch;
  logic [W-1:0]  rd_mux;

  assign port_acc = (wr_en || rd_en) && addr == A_DATA;
  assign clr_req  = wr_en && addr == A_CTRL && !wdata[2];
  assign mismatch = |((sync_q[W-1:CHG_LO] ^ snap_q) & dir_q[W-1:CHG_LO]);

  assign pin_out = lat_q;
  assign pin_oe  = ~dir_q;
  assign pull_en = dir_q & {W{~pull_dis_q}};
  assign irq     = flag_q & irq_en_q;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_DATA:  rd_mux = sync_q;
      A_DIR:   rd_mux = dir_q;
      A_CTRL:  rd_mux[2:0] = {flag_q, irq_en_q, pull_dis_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q     <= '0;
      sync_q     <= '0;
      lat_q      <= '0;
      dir_q      <= '1;
      snap_q     <= '0;
      pull_dis_q <= 1'b1;
      irq_en_q   <= 1'b0;
      flag_q     <= 1'b0;
      rdata      <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      if (wr_en && addr == A_DATA) lat_q <= wdata;
      if (wr_en && addr == A_DIR)  dir_q <= wdata;
      if (wr_en && addr == A_CTRL) begin
        pull_dis_q <= wdata[0];
        irq_en_q   <= wdata[1];
      end
      if (rd_en) rdata <= rd_mux;
      if (port_acc) snap_q <= sync_q[W-1:CHG_LO];
      if (mismatch)     flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end
endmodule

module gpio_chg_port_chk #(
  parameter int W      = 8,
  parameter int CHG_LO = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [1:0]          addr,
  input logic                clr_bit,
  input logic [W-1:0]        pin_oe,
  input logic [W-1:0]        pull_en,
  input logic                irq,
  input logic                flag_q,
  input logic [W-1:0]        sync_q,
  input logic [W-1:0]        dir_q,
  input logic [W-CHG_LO-1:0] snap_q
);
  logic acc, clr, mis;
  assign acc = (wr_en || rd_en) && addr == 2'd0;
  assign clr = wr_en && addr == 2'd2 && !clr_bit;
  assign mis = |((sync_q[W-1:CHG_LO] ^ snap_q) & dir_q[W-1:CHG_LO]);

  assert_no_pull_on_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & pin_oe) == '0);
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mis |=> flag_q);
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !mis) |=> !flag_q);
  assert_snap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> snap_q == $past(sync_q[W-1:CHG_LO]));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W), .CHG_LO(CHG_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .clr_bit(wdata[2]), .pin_oe(pin_oe), .pull_en(pull_en), .irq(irq),
  .flag_q(flag_q), .sync_q(sync_q), .dir_q(dir_q), .snap_q(snap_q)
);

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pin_in = 0;
  logic [7:0] rdata, pin_out, pin_oe, pull_en;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_chg_port uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .irq(irq));

  // reference model built from the requirements
  logic [7:0] m_s1, m_s2, m_lat, m_dir, m_rd;
  logic [3:0] m_snap;
  logic m_pd, m_en, m_flag;

  function automatic logic f_mis(logic [7:0] s, logic [3:0] sn, logic [7:0] d);
    return |((s[7:4] ^ sn) & d[7:4]);
  endfunction
  function automatic logic [7:0] f_pull(logic [7:0] d, logic pd);
    return pd ? 8'h00 : d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_lat <= 0; m_dir <= 8'hFF; m_rd <= 0;
      m_snap <= 0; m_pd <= 1; m_en <= 0; m_flag <= 0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1;
      if (wr_en && addr == 0) m_lat <= wdata;
      if (wr_en && addr == 1) m_dir <= wdata;
      if (wr_en && addr == 2) begin m_pd <= wdata[0]; m_en <= wdata[1]; end
      if (rd_en) m_rd <= (addr == 0) ? m_s2 : (addr == 1) ? m_dir :
                         (addr == 2) ? {5'b0, m_flag, m_en, m_pd} : 8'h00;
      if ((wr_en || rd_en) && addr == 0) m_snap <= m_s2[7:4];
      if (f_mis(m_s2, m_snap, m_dir)) m_flag <= 1;
      else if (wr_en && addr == 2 && !wdata[2]) m_flag <= 0;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 pin_oe", pin_oe, ~m_dir);
    chk("R1 pin_out", pin_out, m_lat);
    chk("R2 pull_en", pull_en, f_pull(m_dir, m_pd));
    chk("R8 irq", {7'b0, irq}, {7'b0, m_flag & m_en});
    chk("R4 rdata", rdata, m_rd);
  endtask

  task automatic step(logic w, logic r, logic [1:0] a, logic [7:0] d);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3 reset state
    chk("R3 pin_oe", pin_oe, 8'h00);
    chk("R3 pull_en", pull_en, 8'h00);
    chk("R3 irq", {7'b0, irq}, 8'h00);
    step(0, 1, 1, 0); chk("R3 dir", rdata, 8'hFF);
    step(0, 1, 2, 0); chk("R3 ctrl", rdata, 8'h01);
    step(0, 1, 0, 0); chk("R3 port", rdata, 8'h00);
    // R1 R2
    step(1, 0, 0, 8'hA5); chk("R1 latch", pin_out, 8'hA5);
    step(1, 0, 1, 8'h0F); chk("R1 oe", pin_oe, 8'hF0);
    step(1, 0, 2, 8'h06); chk("R2 pulls on", pull_en, 8'h0F);
    step(1, 0, 1, 8'hFF); chk("R2 follows dir", pull_en, 8'hFF);
    step(1, 0, 2, 8'h07); chk("R2 pulls off", pull_en, 8'h00);
    // R5 low pin change: no flag
    pin_in = 8'h01; idle(4);
    step(0, 1, 2, 0); chk("R5 low pin", rdata & 8'h04, 8'h00);
    step(0, 1, 0, 0); chk("R4 sync read", rdata, 8'h01);
    // R5 input upper pin sets flag; R8 irq with enable
    pin_in = 8'h41; idle(3);
    chk("R8 irq set", {7'b0, irq}, 8'h01);
    // R7 clear while mismatch persists fails
    step(1, 0, 2, 8'h03); idle(1);
    chk("R7 clear lost", {7'b0, irq}, 8'h01);
    // R6 port read ends mismatch, then clear works
    step(0, 1, 0, 0); chk("R6 read value", rdata, 8'h41);
    step(1, 0, 2, 8'h03); idle(1);
    chk("R7 clear ok", {7'b0, irq}, 8'h00);
    // R5 upper pin as output excluded
    step(1, 0, 1, 8'h7F);
    pin_in = 8'hC1; idle(4);
    chk("R5 output pin", {7'b0, irq}, 8'h00);
    // R8 flag sets while disabled
    step(1, 0, 2, 8'h01);
    pin_in = 8'h81; idle(4);
    chk("R8 masked irq", {7'b0, irq}, 8'h00);
    step(0, 1, 2, 0); chk("R8 flag while off", rdata, 8'h05);
    // R6 write also reloads snapshot
    step(1, 0, 0, 8'h00); step(1, 0, 2, 8'h03); idle(1);
    chk("R6 write ends mismatch", {7'b0, irq}, 8'h00);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
      case (op)
        0, 1: step(0, 1, 2'($urandom), 0);
        2:    step(1, 0, 0, 8'($urandom));
        3:    step(1, 0, 1, 8'($urandom));
        4:    step(1, 0, 2, 8'($urandom));
        5:    step(1, 1, 0, 8'($urandom));
        default: step(0, 0, 0, 0);
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule